// File: doc/BRIEF.md
# Pseudo-Static RAM Power Sequencer

This block owns the two chip-level enables of a pseudo-static RAM whose contents are lost in its lowest power state. The secondary enable `ce2` keeps the array powered while high and drops it into deep power-down while low. The block also has a blocking signal that forces the primary chip enable inactive. After power becomes good, the sequencer keeps the memory idle for a power-on settling window. It then raises `memReady`, and the access logic elsewhere uses that signal to gate its read and write cycles.

On a sleep request the sequencer waits for any access in flight to finish. It then blocks the primary enable and drops `ce2` one cycle later. It keeps `ce2` low for at least the minimum deep power-down pulse, and a wake request that arrives early is held until that pulse is complete. On wake it raises `ce2` and sets a sticky `dataLost` flag, because the array no longer holds valid data. It then waits out a recovery window before declaring the memory ready again. All windows are given in nanoseconds and are converted to clock cycles using the clock period parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the power-on window completes: `ce2`=1, `ce1Block`=1, `memReady`=0, `dataLost`=0.
- R2: `memReady` rises on the PWRON_CYC-th consecutive clock edge that samples `powerGood` high. A cycle with `powerGood` low restarts the count from zero.
- R3: Whenever `memReady`=1, `ce2`=1 and `ce1Block`=0.
- R4: A sleep request (a one-cycle pulse is enough) is remembered in the ready state. The sequence starts on the first edge that samples `accessBusy` low, and `memReady` stays 1 until then.
- R5: At the edge that starts the sequence, `ce1Block` goes to 1 and `memReady` goes to 0 while `ce2` stays 1. `ce2` falls on the following edge.
- R6: With `ce2` falling at edge E and the first wake request sampled at edge E+w+1, `ce2` rises at edge E+max(DPD_CYC, w+1).
- R7: `memReady` rises exactly WAKE_CYC edges after `ce2` rises. `ce1Block` stays 1 in between.
- R8: `dataLost` goes to 1 on the edge where `ce2` rises and stays 1 until an edge samples `lostAck` high. A set on the same edge wins over the acknowledge.
- R9: `wakeReq` has no effect outside deep power-down, and `sleepReq` has no effect outside the ready state. Neither is remembered for later.
- R10: Each window in cycles is its nanosecond parameter divided by CLK_NS and rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerGood | input | 1 | Supply stable indication |
| accessBusy | input | 1 | An access to the memory is in flight |
| sleepReq | input | 1 | Request to enter deep power-down |
| wakeReq | input | 1 | Request to leave deep power-down |
| lostAck | input | 1 | Host acknowledge that clears `dataLost` |
| ce2 | output | 1 | Secondary enable pin; low selects deep power-down |
| ce1Block | output | 1 | 1 forces the primary chip enable inactive (high) |
| memReady | output | 1 | Accesses are permitted |
| dataLost | output | 1 | Array contents were destroyed by a power-down |

## Verification
A corrupted state register or window counter shows up first on the pins: `ce2` falls without `ce1Block` already high, `ce2` comes back before the minimum pulse, or `memReady` returns too early or too late. Each of these appears on the edge where the wrong transition is taken, so the edge counts the bench measures from each pin change expose any off-by-one. A lost pending flag turns into a sequence that never starts or never ends, and the bench catches it when its cycle count runs past the computed value.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RESET_WAIT,
    ST_READY,
    ST_DPD_ENTER,
    ST_DPD_HOLD,
    ST_WAKE_WAIT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic armSleep;
    logic clrSleep;
    logic armWake;
    logic clrWake;
    logic setLost;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pwronDone;
    logic dpdDone;
    logic wakeDone;
    logic sleepWant;
    logic wakeWant;
  } dpStatus_t;

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
  import psram_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerGood,
  input  logic        accessBusy,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        ce2,
  output logic        ce1Block,
  output logic        memReady
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_RESET_WAIT: begin
        if (!powerGood) begin
          strobe.timerClr = 1'b1;
        end else if (status.pwronDone) begin
          nextState = ST_READY;
        end else begin
          strobe.timerRun = 1'b1;
        end
      end
      ST_READY: begin
        strobe.armSleep = 1'b1;
        if (status.sleepWant && !accessBusy) begin
          nextState       = ST_DPD_ENTER;
          strobe.clrSleep = 1'b1;
        end
      end
      ST_DPD_ENTER: begin
        strobe.timerClr = 1'b1;
        strobe.clrWake  = 1'b1;
        nextState       = ST_DPD_HOLD;
      end
      ST_DPD_HOLD: begin
        strobe.armWake  = 1'b1;
        strobe.timerRun = !status.dpdDone;
        if (status.dpdDone && status.wakeWant) begin
          nextState       = ST_WAKE_WAIT;
          strobe.setLost  = 1'b1;
          strobe.clrWake  = 1'b1;
          strobe.timerRun = 1'b0;
          strobe.timerClr = 1'b1;
        end
      end
      ST_WAKE_WAIT: begin
        if (status.wakeDone) begin
          nextState = ST_READY;
        end else begin
          strobe.timerRun = 1'b1;
        end
      end
      default: nextState = ST_RESET_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RESET_WAIT;
      ce2      <= 1'b1;
      ce1Block <= 1'b1;
      memReady <= 1'b0;
    end else begin
      state    <= nextState;
      ce2      <= (nextState != ST_DPD_HOLD);
      ce1Block <= (nextState != ST_READY);
      memReady <= (nextState == ST_READY);
    end
  end

endmodule

// File: rtl/psram_pwr_dp.sv
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int unsigned PWRON_CYC = 3750,
  parameter int unsigned DPD_CYC   = 1250000,
  parameter int unsigned WAKE_CYC  = 37500,
  parameter int unsigned CNT_W     = 21
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        wakeReq,
  input  logic        lostAck,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        dataLost
);

  localparam int NUM_WIN = 3;
  localparam int unsigned WIN_LIM [NUM_WIN] = '{PWRON_CYC, DPD_CYC, WAKE_CYC};

  logic [CNT_W-1:0]   winCnt;
  logic [NUM_WIN-1:0] doneVec;
  logic               sleepPend;
  logic               wakePend;

  // one terminal-count compare per window
  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    assign doneVec[i] = (winCnt == CNT_W'(WIN_LIM[i] - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.timerClr) begin
      winCnt <= '0;
    end else if (strobe.timerRun) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepPend <= 1'b0;
      wakePend  <= 1'b0;
      dataLost  <= 1'b0;
    end else begin
      if (strobe.clrSleep)                 sleepPend <= 1'b0;
      else if (strobe.armSleep && sleepReq) sleepPend <= 1'b1;

      if (strobe.clrWake)                  wakePend <= 1'b0;
      else if (strobe.armWake && wakeReq)  wakePend <= 1'b1;

      if (strobe.setLost)                  dataLost <= 1'b1;
      else if (lostAck)                    dataLost <= 1'b0;
    end
  end

  assign status.pwronDone = doneVec[0];
  assign status.dpdDone   = doneVec[1];
  assign status.wakeDone  = doneVec[2];
  assign status.sleepWant = sleepPend | sleepReq;
  assign status.wakeWant  = wakePend | wakeReq;

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned PWRON_NS = 30000,
  parameter int unsigned DPD_NS   = 10000000,
  parameter int unsigned WAKE_NS  = 300000
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic accessBusy,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic lostAck,
  output logic ce2,
  output logic ce1Block,
  output logic memReady,
  output logic dataLost
);

  localparam int unsigned PWRON_CYC = nsToCycles(PWRON_NS, CLK_NS);
  localparam int unsigned DPD_CYC   = nsToCycles(DPD_NS, CLK_NS);
  localparam int unsigned WAKE_CYC  = nsToCycles(WAKE_NS, CLK_NS);
  localparam int unsigned MAX_A     = (PWRON_CYC > DPD_CYC) ? PWRON_CYC : DPD_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  psram_pwr_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerGood  (powerGood),
    .accessBusy (accessBusy),
    .status     (status),
    .strobe     (strobe),
    .ce2        (ce2),
    .ce1Block   (ce1Block),
    .memReady   (memReady)
  );

  psram_pwr_dp #(
    .PWRON_CYC (PWRON_CYC),
    .DPD_CYC   (DPD_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .CNT_W     (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .lostAck  (lostAck),
    .strobe   (strobe),
    .status   (status),
    .dataLost (dataLost)
  );

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int unsigned DPD_CYC  = 1250000,
  parameter int unsigned WAKE_CYC = 37500
) (
  input logic clk,
  input logic rstN,
  input logic accessBusy,
  input logic lostAck,
  input logic ce2,
  input logic ce1Block,
  input logic memReady,
  input logic dataLost
);

  int unsigned lowRun;
  int unsigned highRun;
  logic        sawLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= 0;
      highRun <= 0;
      sawLow  <= 1'b0;
    end else begin
      lowRun  <= ce2 ? 0 : ((lowRun == 32'hFFFF_FFFF) ? lowRun : lowRun + 1);
      highRun <= !ce2 ? 0 : ((highRun == 32'hFFFF_FFFF) ? highRun : highRun + 1);
      if (!ce2) sawLow <= 1'b1;
    end
  end

  a_r3_ready_pins: assert property (@(posedge clk) disable iff (!rstN)
    memReady |-> (ce2 && !ce1Block));

  a_r4_idle_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ce1Block) |-> !$past(accessBusy));

  a_r5_ce1_leads_ce2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ce2) |-> (ce1Block && $past(ce1Block) && !memReady));

  a_r6_low_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ce2) |-> (lowRun >= DPD_CYC));

  a_r7_wake_gap: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReady) && sawLow) |-> (highRun >= WAKE_CYC));

  a_r8_lost_on_exit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataLost) |-> $rose(ce2));

  a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (dataLost && !lostAck) |=> dataLost);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .DPD_CYC  (DPD_CYC),
  .WAKE_CYC (WAKE_CYC)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .accessBusy (accessBusy),
  .lostAck    (lostAck),
  .ce2        (ce2),
  .ce1Block   (ce1Block),
  .memReady   (memReady),
  .dataLost   (dataLost)
);

// File: tb/psram_pwr_seq_test.sv
module psram_pwr_seq_test;

  localparam int unsigned T_CLK    = 8;
  localparam int unsigned T_PWRON  = 400;
  localparam int unsigned T_DPD    = 1600;
  localparam int unsigned T_WAKE   = 796;

  function automatic int ceilCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int expRise(input int dpd, input int w);
    return (dpd > w + 1) ? dpd : w + 1;
  endfunction

  localparam int PW = ceilCyc(T_PWRON, T_CLK);
  localparam int DP = ceilCyc(T_DPD, T_CLK);
  localparam int WK = ceilCyc(T_WAKE, T_CLK);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0;
  logic accessBusy = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic lostAck = 1'b0;
  logic ce2, ce1Block, memReady, dataLost;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  psram_pwr_seq #(
    .CLK_NS   (T_CLK),
    .PWRON_NS (T_PWRON),
    .DPD_NS   (T_DPD),
    .WAKE_NS  (T_WAKE)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .powerGood  (powerGood),
    .accessBusy (accessBusy),
    .sleepReq   (sleepReq),
    .wakeReq    (wakeReq),
    .lostAck    (lostAck),
    .ce2        (ce2),
    .ce1Block   (ce1Block),
    .memReady   (memReady),
    .dataLost   (dataLost)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  // one full sleep / wake round trip with checks
  task automatic sleepCycle(input int b, input int w, input bit poke, input bit ackHold);
    int k;
    chkEq("R3", "memReady before sleep", int'(memReady), 1);
    accessBusy = (b > 0);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    if (b > 0) begin
      chkEq("R4", "memReady while busy", int'(memReady), 1);
      chkEq("R4", "ce1Block while busy", int'(ce1Block), 0);
      repeat (b - 1) @(negedge clk);
      accessBusy = 1'b0;
      @(negedge clk);
    end
    chkEq("R5", "ce1Block at entry", int'(ce1Block), 1);
    chkEq("R5", "ce2 at entry", int'(ce2), 1);
    chkEq("R5", "memReady at entry", int'(memReady), 0);
    @(negedge clk);
    chkEq("R5", "ce2 after entry", int'(ce2), 0);
    if (ackHold) lostAck = 1'b1;
    k = 0;
    forever begin
      wakeReq = (k == w);
      @(negedge clk);
      k++;
      if (ce2 || k > 2000) break;
    end
    wakeReq = 1'b0;
    chkEq("R6", "ce2 low edges", k, expRise(DP, w));
    chkEq("R8", "dataLost at wake", int'(dataLost), 1);
    k = 0;
    forever begin
      sleepReq = poke && (k == 3);
      @(negedge clk);
      k++;
      if (ackHold && k == 1) chkEq("R8", "ack after set", int'(dataLost), 0);
      if (memReady || k > 2000) break;
      if (!ce1Block) chkEq("R7", "ce1Block in recovery", int'(ce1Block), 1);
    end
    sleepReq = 1'b0;
    lostAck = 1'b0;
    chkEq("R7 R10", "recovery edges", k, WK);
    if (poke) begin
      repeat (5) @(negedge clk);
      chkEq("R9", "sleep in recovery ignored (ready)", int'(memReady), 1);
      chkEq("R9", "sleep in recovery ignored (ce2)", int'(ce2), 1);
    end
    if (!ackHold) begin
      chkEq("R8", "dataLost sticky", int'(dataLost), 1);
      lostAck = 1'b1;
      @(negedge clk);
      lostAck = 1'b0;
      chkEq("R8", "dataLost acked", int'(dataLost), 0);
    end
  endtask

  initial begin
    #(T_CLK * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    chkEq("R1", "ce2 in reset", int'(ce2), 1);
    chkEq("R1", "ce1Block in reset", int'(ce1Block), 1);
    chkEq("R1", "memReady in reset", int'(memReady), 0);
    chkEq("R1", "dataLost in reset", int'(dataLost), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkEq("R1", "memReady without power", int'(memReady), 0);

    // power dips part way: count must restart
    powerGood = 1'b1;
    repeat (PW - 10) @(negedge clk);
    powerGood = 1'b0;
    @(negedge clk);
    powerGood = 1'b1;
    repeat (PW - 1) @(negedge clk);
    chkEq("R2", "memReady one edge early", int'(memReady), 0);
    @(negedge clk);
    chkEq("R2", "memReady on time", int'(memReady), 1);
    chkEq("R3", "ce1Block when ready", int'(ce1Block), 0);
    chkEq("R3", "ce2 when ready", int'(ce2), 1);

    // wake pulse while ready must be forgotten
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    chkEq("R9", "wake in ready ignored", int'(memReady), 1);
    sleepCycle(0, DP + 20, 1'b0, 1'b0);

    // directed boundaries of the minimum pulse
    sleepCycle(0, DP - 1, 1'b0, 1'b0);
    sleepCycle(3, DP, 1'b1, 1'b0);
    sleepCycle(1, 0, 1'b0, 1'b1);

    // constrained random round trips
    for (int i = 0; i < 8; i++) begin
      int b, w;
      bit p;
      b = $urandom_range(0, 12);
      w = $urandom_range(0, 320);
      p = 1'($urandom_range(0, 1));
      sleepCycle(b, w, p, 1'b0);
      repeat ($urandom_range(1, 6)) @(negedge clk);
    end

    finished = 1'b1;
    finish();
  end

endmodule